// File: doc/BRIEF.md
# Performance Monitor Counter Bank

The block counts hardware activity for later software inspection. It holds a configurable number of event counters, each fed by its own pulse input, and one 64-bit cycle counter. All of its state sits behind a simple word-addressed register port: a 4-bit address, a write strobe, 32-bit write data and combinational read data. Writes take effect at the rising clock edge in which `reg_we` is sampled high.

Enables, interrupt enables and overflow flags are each kept as a 32-bit mask. Each mask has separate set and clear addresses, so software never needs a read-modify-write. Bit i of a mask belongs to event counter i, and bit 31 belongs to the cycle counter. An overflow is recorded when the watched bit of a counter goes from 1 to 0. A level interrupt is raised while the bank is globally enabled and any enabled overflow flag is pending. A software-increment write can bump selected counters whose event type is zero. A select register gives indirect access to one event counter and its type field.

Top module: `pmu_bank`

## Requirements
- R1: The control register (address 0) stores only bit 0 (global enable), bit 3 (divide cycle clock by 64), bit 4 (long cycle counter) and bit 5 (long event counters). Bit 1 (event reset) and bit 2 (cycle reset) act on the write and read back as 0. Bits 15:11 read back as N_EVT, and all other bits read back as 0.
- R2: For each mask pair, a write to the set address (enable 1, overflow 3, interrupt enable 5) ORs the write data into the mask. A write to the clear address (enable 2, overflow 4, interrupt enable 6) clears every bit that is 1 in the data. Both addresses of a pair read the mask. Only bits 0..N_EVT-1 and bit 31 are implemented.
- R3: An event counter advances on its pulse only while control bit 0 and its own enable bit are both 1. The cycle counter advances only while control bit 0 and enable bit 31 are both 1.
- R4: When a counter's watched bit goes from 1 to 0 during an increment, the counter's overflow bit is set. For event counters the watched bit is 63 when control bit 5 is 1 and 31 otherwise. With control bit 5 at 0, an event counter wraps modulo 2^32 and its upper half becomes 0.
- R5: The cycle counter's overflow sets overflow bit 31. Its watched bit is 63 when control bit 4 is 1 and 31 otherwise. The counter is readable and writable as two halves: low at address 12, high at address 13.
- R6: `irq` is 1 exactly when control bit 0 is 1 and the AND of the interrupt-enable mask with the overflow mask is nonzero.
- R7: A write to address 7 adds 1 to every event counter i that meets three conditions: data bit i is 1, the counter is enabled as in R3, and its event type is 0. The address reads as 0.
- R8: A control write with bit 2 set zeroes the cycle counter and its divider. A control write with bit 1 set zeroes every event counter.
- R9: When control bit 3 is 1 and bit 4 is 0, the cycle counter advances once per 64 enabled cycles. Otherwise it advances once per enabled cycle.
- R10: The select register (address 8) keeps data bits 4:0. Addresses 9 (counter low word), 10 (counter high word) and 11 (event type, TYPE_W bits) reach the counter the select register names. A selection at or above N_EVT reads 0 and ignores writes.
- R11: The user-enable register (address 14) keeps bits 3:0 when USR_EXT is 1 and only bit 0 otherwise.
- R12: An event pulse and a software increment that reach the same counter in the same cycle add 2.
- R13: After reset, every register, counter and mask reads 0, except the control register, which reads CTRL_RST masked to its stored bits, plus the N_EVT field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_in | input | N_EVT | Event pulses, one per counter |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, assertions check the following:
- A disabled counter holds its value.
- Setting and clearing a mask leaves exactly the written bits set or cleared.
- Between divider ticks the cycle counter stays put, and each tick adds exactly one.
- A simultaneous event and software increment adds two.
- The interrupt persists until something can clear it.
- The select field and the read-only count field are correct.

The bench's scenarios show the rest:
- The exact bit positions where overflow is caught in short and long modes.
- The once-per-64 cadence of the divided cycle counter.
- The filtering of software increments by event type and enable.
- The mix of all operations under random traffic.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int PMU_AW = 4;
  localparam int DIV_LOG2 = 6;

  localparam logic [PMU_AW-1:0] A_CTRL  = 4'd0;
  localparam logic [PMU_AW-1:0] A_ENSET = 4'd1;
  localparam logic [PMU_AW-1:0] A_ENCLR = 4'd2;
  localparam logic [PMU_AW-1:0] A_OVSET = 4'd3;
  localparam logic [PMU_AW-1:0] A_OVCLR = 4'd4;
  localparam logic [PMU_AW-1:0] A_IESET = 4'd5;
  localparam logic [PMU_AW-1:0] A_IECLR = 4'd6;
  localparam logic [PMU_AW-1:0] A_SWINC = 4'd7;
  localparam logic [PMU_AW-1:0] A_SEL   = 4'd8;
  localparam logic [PMU_AW-1:0] A_XCNT  = 4'd9;
  localparam logic [PMU_AW-1:0] A_XCNTH = 4'd10;
  localparam logic [PMU_AW-1:0] A_XTYPE = 4'd11;
  localparam logic [PMU_AW-1:0] A_CYCLO = 4'd12;
  localparam logic [PMU_AW-1:0] A_CYCHI = 4'd13;
  localparam logic [PMU_AW-1:0] A_USER  = 4'd14;

  localparam int C_EN    = 0;
  localparam int C_EVRST = 1;
  localparam int C_CYRST = 2;
  localparam int C_DIV   = 3;
  localparam int C_LCYC  = 4;
  localparam int C_LEV   = 5;
  localparam logic [31:0] CTRL_WMASK = 32'h0000_0039;
  localparam int NFIELD_LSB = 11;

  // next value of a counter after adding inc; short mode keeps 32 bits
  function automatic logic [63:0] pmu_bump(input logic [63:0] old,
                                           input logic [1:0] inc,
                                           input logic wide);
    logic [63:0] s;
    s = old + 64'(inc);
    return wide ? s : {32'h0, s[31:0]};
  endfunction

  // watched bit fell from 1 to 0
  function automatic logic pmu_wrapped(input logic [63:0] old,
                                       input logic [63:0] nxt,
                                       input logic wide);
    logic [63:0] m;
    m = wide ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
    return |(old & ~nxt & m);
  endfunction
endpackage

// File: rtl/pmu_setclr.sv
module pmu_setclr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] set_bits, clr_bits;
  assign set_bits = set_we ? wdata : '0;
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_bits) | set_bits | hw_set;
  end

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(wdata)) == $past(wdata)));
  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((q & $past(wdata) & ~$past(hw_set)) == '0));
endmodule

// File: rtl/pmu_evcnt.sv
module pmu_evcnt
  import pmu_pkg::*;
#(
  parameter int TYPE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              ev,
  input  logic              sw_inc,
  input  logic              wide,
  input  logic              clr_all,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_type,
  input  logic [31:0]       wdata,
  output logic [63:0]       count,
  output logic [TYPE_W-1:0] evtype,
  output logic              ovf
);
  logic        ev_hit, sw_hit, bumped;
  logic [1:0]  inc;
  logic [63:0] nxt;

  assign ev_hit = cnt_en & ev;
  assign sw_hit = cnt_en & sw_inc & (evtype == '0);
  assign inc    = {1'b0, ev_hit} + {1'b0, sw_hit};
  assign nxt    = pmu_bump(count, inc, wide);
  assign bumped = (inc != 2'd0) & ~clr_all & ~wr_lo & ~wr_hi;
  assign ovf    = bumped & pmu_wrapped(count, nxt, wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clr_all) count <= '0;
    else if (wr_lo)   count <= {count[63:32], wdata};
    else if (wr_hi)   count <= {wdata, count[31:0]};
    else if (bumped)  count <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       evtype <= '0;
    else if (wr_type) evtype <= wdata[TYPE_W-1:0];
  end

  // R3
  evcnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr_all && !wr_lo && !wr_hi) |=> $stable(count));
  // R12
  evcnt_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && sw_hit && bumped && !wide) |=> (count[31:0] == $past(count[31:0]) + 32'd2));
  // R4
  evcnt_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bumped && !wide) |=> (count[63:32] == 32'h0));
endmodule

// File: rtl/pmu_cyccnt.sv
module pmu_cyccnt
  import pmu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        div_mode,
  input  logic        wide,
  input  logic        clr,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [63:0] count,
  output logic        ovf
);
  logic [DIV_LOG2-1:0] pre;
  logic                tick, bumped;
  logic [63:0]         nxt;

  assign tick   = run & (~div_mode | (pre == {DIV_LOG2{1'b1}}));
  assign bumped = tick & ~clr & ~wr_lo & ~wr_hi;
  assign nxt    = pmu_bump(count, 2'd1, 1'b1);
  assign ovf    = bumped & pmu_wrapped(count, nxt, wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre <= '0;
    else if (clr)              pre <= '0;
    else if (run && div_mode)  pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (wr_lo)  count <= {count[63:32], wdata};
    else if (wr_hi)  count <= {wdata, count[31:0]};
    else if (bumped) count <= nxt;
  end

  // R9
  cyc_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr && !wr_lo && !wr_hi) |=> $stable(count));
  // R5
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bumped |=> (count == $past(count) + 64'd1));
endmodule

// File: rtl/pmu_bank.sv
module pmu_bank
  import pmu_pkg::*;
#(
  parameter int          N_EVT    = 4,
  parameter int          TYPE_W   = 10,
  parameter logic [31:0] CTRL_RST = 32'h0000_0008,
  parameter bit          USR_EXT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N_EVT-1:0]  evt_in,
  output logic              irq
);
  localparam logic [31:0] IMPL = 32'h8000_0000 | ((32'd1 << N_EVT) - 32'd1);
  localparam logic [3:0]  USR_MASK = USR_EXT ? 4'hF : 4'h1;

  logic [31:0] ctrl_q, en_q, ovs_q, ie_q, hw_ovf, wmask_data;
  logic [4:0]  sel_q;
  logic [3:0]  usr_q;
  logic        wr_ctrl, wr_swinc, wr_sel, wr_xcnt, wr_xcnth, wr_xtype, wr_usr;
  logic        sel_valid, cyc_ovf;
  logic [63:0] cyc_cnt, xcnt;
  logic [TYPE_W-1:0] xtyp;
  logic [63:0]       ev_cnt [N_EVT];
  logic [TYPE_W-1:0] ev_typ [N_EVT];
  logic [N_EVT-1:0]  ev_ovf;

  assign wr_ctrl   = reg_we && reg_addr == A_CTRL;
  assign wr_swinc  = reg_we && reg_addr == A_SWINC;
  assign wr_sel    = reg_we && reg_addr == A_SEL;
  assign wr_xcnt   = reg_we && reg_addr == A_XCNT;
  assign wr_xcnth  = reg_we && reg_addr == A_XCNTH;
  assign wr_xtype  = reg_we && reg_addr == A_XTYPE;
  assign wr_usr    = reg_we && reg_addr == A_USER;
  assign sel_valid = 32'(sel_q) < N_EVT;
  assign wmask_data = reg_wdata & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST & CTRL_WMASK;
      sel_q  <= '0;
      usr_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_WMASK;
      if (wr_sel)  sel_q  <= reg_wdata[4:0];
      if (wr_usr)  usr_q  <= reg_wdata[3:0] & USR_MASK;
    end
  end

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    pmu_evcnt #(.TYPE_W(TYPE_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en  (ctrl_q[C_EN] & en_q[i]),
      .ev      (evt_in[i]),
      .sw_inc  (wr_swinc & reg_wdata[i]),
      .wide    (ctrl_q[C_LEV]),
      .clr_all (wr_ctrl & reg_wdata[C_EVRST]),
      .wr_lo   (wr_xcnt & sel_valid & (sel_q == 5'(i))),
      .wr_hi   (wr_xcnth & sel_valid & (sel_q == 5'(i))),
      .wr_type (wr_xtype & sel_valid & (sel_q == 5'(i))),
      .wdata   (reg_wdata),
      .count   (ev_cnt[i]),
      .evtype  (ev_typ[i]),
      .ovf     (ev_ovf[i])
    );
  end

  pmu_cyccnt u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q[C_EN] & en_q[31]),
    .div_mode (ctrl_q[C_DIV] & ~ctrl_q[C_LCYC]),
    .wide     (ctrl_q[C_LCYC]),
    .clr      (wr_ctrl & reg_wdata[C_CYRST]),
    .wr_lo    (reg_we && reg_addr == A_CYCLO),
    .wr_hi    (reg_we && reg_addr == A_CYCHI),
    .wdata    (reg_wdata),
    .count    (cyc_cnt),
    .ovf      (cyc_ovf)
  );

  always_comb begin
    hw_ovf = '0;
    hw_ovf[N_EVT-1:0] = ev_ovf;
    hw_ovf[31] = cyc_ovf;
  end

  pmu_setclr #(.W(32)) u_en (
    .clk(clk), .rst_n(rst_n),
    .set_we(reg_we && reg_addr == A_ENSET), .clr_we(reg_we && reg_addr == A_ENCLR),
    .wdata(wmask_data), .hw_set(32'h0), .q(en_q));
  pmu_setclr #(.W(32)) u_ovs (
    .clk(clk), .rst_n(rst_n),
    .set_we(reg_we && reg_addr == A_OVSET), .clr_we(reg_we && reg_addr == A_OVCLR),
    .wdata(wmask_data), .hw_set(hw_ovf), .q(ovs_q));
  pmu_setclr #(.W(32)) u_ie (
    .clk(clk), .rst_n(rst_n),
    .set_we(reg_we && reg_addr == A_IESET), .clr_we(reg_we && reg_addr == A_IECLR),
    .wdata(wmask_data), .hw_set(32'h0), .q(ie_q));

  assign irq = ctrl_q[C_EN] & |(ie_q & ovs_q);

  always_comb begin
    xcnt = '0;
    xtyp = '0;
    for (int k = 0; k < N_EVT; k++) begin
      if (sel_q == 5'(k)) begin
        xcnt = ev_cnt[k];
        xtyp = ev_typ[k];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:           reg_rdata = ctrl_q | (32'(N_EVT) << NFIELD_LSB);
      A_ENSET, A_ENCLR: reg_rdata = en_q;
      A_OVSET, A_OVCLR: reg_rdata = ovs_q;
      A_IESET, A_IECLR: reg_rdata = ie_q;
      A_SEL:            reg_rdata = {27'h0, sel_q};
      A_XCNT:           reg_rdata = xcnt[31:0];
      A_XCNTH:          reg_rdata = xcnt[63:32];
      A_XTYPE:          reg_rdata = 32'(xtyp);
      A_CYCLO:          reg_rdata = cyc_cnt[31:0];
      A_CYCHI:          reg_rdata = cyc_cnt[63:32];
      A_USER:           reg_rdata = {28'h0, usr_q};
      default:          reg_rdata = 32'h0;
    endcase
  end

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_ctrl && !(reg_we && (reg_addr == A_OVCLR || reg_addr == A_IECLR)))
      |=> irq);
  // R10
  sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (sel_q == $past(reg_wdata[4:0])));
  // R11
  usr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_USER) |-> ((reg_rdata[3:0] & ~USR_MASK) == 4'h0 && reg_rdata[31:4] == '0));
  // R1
  ctrl_nfield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> (reg_rdata[15:11] == 5'(N_EVT)));
  // R8
  evrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[C_EVRST]) |=> (ev_cnt[0] == 64'h0));
endmodule

// File: tb/tb_pmu_bank.sv
`timescale 1ns/1ps
module tb_pmu_bank;
  localparam int N = 4;
  localparam int TW = 10;
  localparam logic [31:0] CRST = 32'h0000_0008;
  localparam logic [31:0] IMPLM = 32'h8000_000F;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, irq;
  logic [3:0] reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'h0, reg_rdata;
  logic [N-1:0] evt_in = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmu_bank #(.N_EVT(N), .TYPE_W(TW), .CTRL_RST(CRST), .USR_EXT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq));

  // bench model
  logic [31:0] m_ctrl, m_en, m_ovs, m_ie;
  logic [4:0]  m_sel;
  logic [3:0]  m_usr;
  logic [63:0] m_cnt [N];
  logic [TW-1:0] m_typ [N];
  logic [63:0] m_cyc;
  int m_pre;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    logic [63:0] c;
    c = (m_sel < 5'(N)) ? m_cnt[m_sel] : 64'h0;
    case (a)
      4'd0: return m_ctrl | (32'(N) << 11);
      4'd1, 4'd2: return m_en;
      4'd3, 4'd4: return m_ovs;
      4'd5, 4'd6: return m_ie;
      4'd8: return {27'h0, m_sel};
      4'd9: return c[31:0];
      4'd10: return c[63:32];
      4'd11: return (m_sel < 5'(N)) ? 32'(m_typ[m_sel]) : 32'h0;
      4'd12: return m_cyc[31:0];
      4'd13: return m_cyc[63:32];
      4'd14: return {28'h0, m_usr};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R1 ctrl";
      4'd1, 4'd2, 4'd5, 4'd6: return "R2 mask";
      4'd3, 4'd4: return "R4 overflow";
      4'd7: return "R7 swinc";
      4'd8, 4'd11: return "R10 select";
      4'd9, 4'd10: return "R3 counter";
      4'd12, 4'd13: return "R5 cycle";
      default: return "R11 user";
    endcase
  endfunction

  task automatic model_step(input logic we, input logic [3:0] a, input logic [31:0] d,
                            input logic [N-1:0] ev);
    logic cen, lev, run, divm, tk;
    logic [31:0] hw, dm;
    logic [63:0] o, nw;
    int b;
    cen = m_ctrl[0]; lev = m_ctrl[5]; hw = 0; dm = d & IMPLM;
    for (int i = 0; i < N; i++) begin
      int inc;
      inc = 0;
      if (cen && m_en[i] && ev[i]) inc++;
      if (we && a == 4'd7 && d[i] && cen && m_en[i] && m_typ[i] == '0) inc++;
      if (we && a == 4'd0 && d[1]) m_cnt[i] = 0;
      else if (we && a == 4'd9 && m_sel == 5'(i)) m_cnt[i][31:0] = d;
      else if (we && a == 4'd10 && m_sel == 5'(i)) m_cnt[i][63:32] = d;
      else if (inc > 0) begin
        o = m_cnt[i]; nw = o + 64'(inc);
        if (!lev) nw[63:32] = 0;
        b = lev ? 63 : 31;
        if (o[b] && !nw[b]) hw[i] = 1'b1;
        m_cnt[i] = nw;
      end
      if (we && a == 4'd11 && m_sel == 5'(i)) m_typ[i] = d[TW-1:0];
    end
    run = cen && m_en[31]; divm = m_ctrl[3] && !m_ctrl[4];
    tk = run && (!divm || m_pre == 63);
    if (we && a == 4'd0 && d[2]) begin m_cyc = 0; m_pre = 0; end
    else begin
      if (run && divm) m_pre = (m_pre + 1) % 64;
      if (we && a == 4'd12) m_cyc[31:0] = d;
      else if (we && a == 4'd13) m_cyc[63:32] = d;
      else if (tk) begin
        o = m_cyc; nw = o + 1; b = m_ctrl[4] ? 63 : 31;
        if (o[b] && !nw[b]) hw[31] = 1'b1;
        m_cyc = nw;
      end
    end
    if (we && a == 4'd1) m_en = m_en | dm;
    if (we && a == 4'd2) m_en = m_en & ~dm;
    if (we && a == 4'd5) m_ie = m_ie | dm;
    if (we && a == 4'd6) m_ie = m_ie & ~dm;
    m_ovs = (m_ovs & ~((we && a == 4'd4) ? dm : 32'h0)) | ((we && a == 4'd3) ? dm : 32'h0) | hw;
    if (we && a == 4'd0) m_ctrl = d & 32'h39;
    if (we && a == 4'd8) m_sel = d[4:0];
    if (we && a == 4'd14) m_usr = d[3:0];
  endtask

  task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d,
                     input logic [N-1:0] ev);
    reg_we = we; reg_addr = a; reg_wdata = d; evt_in = ev;
    model_step(we, a, d, ev);
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; evt_in = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, '0);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    reg_we = 1'b0; reg_addr = a; #1;
    chk(tag, 64'(reg_rdata), 64'(exp_read(a)));
    cyc(1'b0, a, 32'h0, '0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 4'd7, 32'h0, '0);
  endtask

  task automatic sweep();
    for (int a = 0; a < 15; a++) rd(4'(a), tag_of(4'(a)));
    #1; chk("R6 irq", 64'(irq), 64'(m_ctrl[0] && |(m_ie & m_ovs)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ctrl = CRST & 32'h39; m_en = 0; m_ovs = 0; m_ie = 0; m_sel = 0; m_usr = 0;
    m_cyc = 0; m_pre = 0;
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_typ[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    for (int a = 0; a < 15; a++) begin
      reg_addr = 4'(a); #1;
      chk("R13 reset", 64'(reg_rdata), (a == 0) ? 64'h2008 : 64'h0);
      @(negedge clk);
    end
    #1; chk("R13 irq reset", 64'(irq), 64'h0);
    @(negedge clk);

    // R1 stored bits and count field
    wr(4'd0, 32'hFFFF_FFFF);
    reg_addr = 4'd0; #1; chk("R1 ctrl readback", 64'(reg_rdata), 64'h2039);
    @(negedge clk);

    // R2 set/clear
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd2, 32'h0000_0005);
    reg_addr = 4'd1; #1; chk("R2 enable mask", 64'(reg_rdata), 64'h8000_000A);
    @(negedge clk);

    // R3 gating
    wr(4'd0, 32'h1);
    for (int k = 0; k < 5; k++) cyc(1'b0, 4'd7, 32'h0, 4'hF);
    wr(4'd8, 32'd1); rd(4'd9, "R3 enabled counter");
    chk("R3 enabled count five", m_cnt[1], 64'd5);
    wr(4'd8, 32'd0); rd(4'd9, "R3 disabled counter");
    wr(4'd0, 32'h0);
    cyc(1'b0, 4'd7, 32'h0, 4'hF);
    wr(4'd8, 32'd3); rd(4'd9, "R3 global off");

    // R4 short wrap and long mode
    wr(4'd0, 32'h1); wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd8, 32'd1); wr(4'd9, 32'hFFFF_FFFE);
    cyc(1'b0, 4'd7, 32'h0, 4'h2); cyc(1'b0, 4'd7, 32'h0, 4'h2);
    reg_addr = 4'd3; #1; chk("R4 short overflow flag", 64'(reg_rdata[1]), 64'h1);
    @(negedge clk);
    rd(4'd9, "R4 wrapped value");
    wr(4'd0, 32'h21); wr(4'd4, 32'hF);
    wr(4'd9, 32'hFFFF_FFFF); wr(4'd10, 32'h0);
    cyc(1'b0, 4'd7, 32'h0, 4'h2);
    reg_addr = 4'd10; #1; chk("R4 long carry", 64'(reg_rdata), 64'h1);
    reg_addr = 4'd3; #1; chk("R4 long no flag", 64'(reg_rdata[1]), 64'h0);
    @(negedge clk);

    // R5 cycle overflow at bit 31 then 63
    wr(4'd0, 32'h1); wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd13, 32'h0); wr(4'd12, 32'hFFFF_FFF0);
    idle(20);
    reg_addr = 4'd3; #1; chk("R5 short cycle flag", 64'(reg_rdata[31]), 64'h1);
    @(negedge clk);
    wr(4'd0, 32'h11); wr(4'd4, 32'h8000_0000);
    wr(4'd13, 32'hFFFF_FFFF); wr(4'd12, 32'hFFFF_FFF0);
    idle(20);
    reg_addr = 4'd3; #1; chk("R5 long cycle flag", 64'(reg_rdata[31]), 64'h1);
    reg_addr = 4'd13; #1; chk("R5 long cycle high", 64'(reg_rdata), 64'h0);
    @(negedge clk);

    // R6 irq
    wr(4'd5, 32'h8000_0000);
    #1; chk("R6 irq on", 64'(irq), 64'h1);
    wr(4'd0, 32'h0);
    #1; chk("R6 irq off when disabled", 64'(irq), 64'h0);
    wr(4'd0, 32'h1); wr(4'd4, 32'h8000_0000);
    #1; chk("R6 irq off after clear", 64'(irq), 64'h0);

    // R7 software increment
    wr(4'd0, 32'h3); wr(4'd1, 32'hF);
    wr(4'd8, 32'd2); wr(4'd11, 32'd5);
    wr(4'd7, 32'hF);
    for (int i = 0; i < N; i++) begin
      wr(4'd8, 32'(i)); rd(4'd9, "R7 swinc per counter");
    end
    chk("R7 typed counter untouched", m_cnt[2], 64'd0);
    wr(4'd2, 32'h8); wr(4'd7, 32'h8);
    wr(4'd8, 32'd3); rd(4'd9, "R7 disabled ignores swinc");

    // R12 event plus software increment
    wr(4'd8, 32'd0); wr(4'd9, 32'd10);
    cyc(1'b1, 4'd7, 32'h1, 4'h1);
    reg_addr = 4'd9; #1; chk("R12 double step", 64'(reg_rdata), 64'd12);
    @(negedge clk);

    // R8 resets
    wr(4'd12, 32'h1234); wr(4'd0, 32'h7);
    reg_addr = 4'd12; #1; chk("R8 cycle reset", 64'(reg_rdata), 64'h0);
    reg_addr = 4'd9; #1; chk("R8 event reset", 64'(reg_rdata), 64'h0);
    @(negedge clk);

    // R9 divider
    wr(4'd0, 32'hD);
    idle(130);
    rd(4'd12, "R9 divided cycle");
    chk("R9 divided cycle two", m_cyc, 64'd2);
    wr(4'd0, 32'h1D);
    idle(10);
    rd(4'd12, "R9 long ignores divider");

    // R10 select
    wr(4'd8, 32'hFFFF_FFFF);
    reg_addr = 4'd8; #1; chk("R10 select width", 64'(reg_rdata), 64'h1F);
    reg_addr = 4'd9; #1; chk("R10 out of range read", 64'(reg_rdata), 64'h0);
    @(negedge clk);

    // R11 user enable
    wr(4'd14, 32'hFFFF_FFFF);
    reg_addr = 4'd14; #1; chk("R11 user bits", 64'(reg_rdata), 64'hF);
    @(negedge clk);

    // random traffic
    for (int it = 0; it < 3000; it++) begin
      logic [3:0] a;
      logic [31:0] d;
      a = 4'($urandom_range(0, 14));
      d = $urandom;
      if (a == 4'd9 || a == 4'd12) d = 32'hFFFF_FFF0 | (d & 32'hF);
      if (a == 4'd8) d = d & 32'h7;
      if (a == 4'd0 && ($urandom_range(0, 3) != 0)) d = d | 32'h1;
      cyc(($urandom_range(0, 3) == 0) && (a != 4'd0 || $urandom_range(0, 3) == 0),
          a, d, N'($urandom));
      if (it % 100 == 99) sweep();
    end
    sweep();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule